// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog that software cannot switch off once it is running. All control goes through one key register: fixed 16-bit codes start the watchdog, feed it, and open or close write access to the prescaler and reload registers. A 12-bit down-counter advances on a tick taken from a selectable clock divider. When the counter runs out, the block raises a reset request for one clock cycle, loads the counter again and keeps running.

Changes to the prescaler or the reload value are not used at once. Each accepted write sets a pending flag in the status register. A fixed synchronisation delay follows. When the flag clears, the new value becomes the one the counter and the divider use. Software can read the stored values back. A feed issued before the flag clears still uses the old reload value.

Register map, which the bench depends on: address 0 is the key register (reads as 0), address 1 the prescaler, address 2 the reload, address 3 the status. Writes use a one-cycle strobe and reads are combinational.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the reload register reads 0xFFF and the prescaler reads 0. Status and the key address read 0, `rst_req` is low, and the watchdog is idle and raises no request.
- R2: Writing 0xCCCC to address 0 starts the watchdog. The counter loads the active reload value RL and the divider restarts. The first request follows RL×D clock cycles after the write edge, where D is the divisor. RL = 0 gives a request after D cycles. Feeding the watchdog while it is idle does not start it.
- R3: Writing 0xAAAA to address 0 loads the counter from the active reload value, restarts the divider count and closes configuration write access.
- R4: Writing 0x5555 to address 0 opens write access to addresses 1 and 2. Writing 0x0000 closes it.
- R5: A write to address 1 or 2 while access is closed changes neither the stored value nor the status.
- R6: Any other value written to address 0 has no effect. It does not start the watchdog, reload the counter or change access.
- R7: Prescaler code c (bits 2:0) selects divisor 4·2^c for c = 0..6. Code 7 selects 256.
- R8: Status bit 0 flags a pending prescaler update and bit 1 a pending reload update. Each bit sets on an accepted write and clears SYNC_DLY (default 3) cycles after the write edge. Only then does the new value take effect.
- R9: A request lasts exactly one cycle. The counter then reloads itself and requests repeat every RL×D cycles. No key write stops the watchdog once it has started.
- R10: Only data bits 11:0 are kept by a reload write and bits 2:0 by a prescaler write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 16 | Combinational read data |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The counter is run with several reload and prescaler pairs: the reset defaults, 6 with divide-by-8, and codes 7, 6 and 3. Comparing the request period against RL×D separates the divisor decode from the reload path and shows that code 7 clamps to 256. Repeated feeds placed before expiry show that a reload also restarts the divider. A feed issued one cycle after a reload write shows the old value still in use until the sync delay ends. Stray key values, writes while access is locked and oversized data are each followed by read-back, so accepted writes can be told apart from ignored ones.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
   localparam logic [15:0] KEY_FEED   = 16'hAAAA;
   localparam logic [15:0] KEY_START  = 16'hCCCC;
   localparam logic [15:0] KEY_UNLOCK = 16'h5555;
   localparam logic [15:0] KEY_LOCK   = 16'h0000;

   typedef enum logic [1:0] {
      ADR_KEY  = 2'd0,
      ADR_PRE  = 2'd1,
      ADR_RLD  = 2'd2,
      ADR_STAT = 2'd3
   } kwdt_addr_e;
endpackage

// File: rtl/kwdt_key_decode.sv
module kwdt_key_decode
   import kwdt_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        key_wr,
   input  logic [15:0] key_val,
   output logic        start_p,
   output logic        feed_p,
   output logic        acc_open,
   output logic        running
);
   assign start_p = key_wr && (key_val == KEY_START);
   assign feed_p  = key_wr && (key_val == KEY_FEED);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_open <= 1'b0;
         running  <= 1'b0;
      end else begin
         if (key_wr) begin
            if (key_val == KEY_UNLOCK)
               acc_open <= 1'b1;
            else if ((key_val == KEY_LOCK) || (key_val == KEY_FEED))
               acc_open <= 1'b0;
         end
         if (start_p)
            running <= 1'b1;
      end
   end
endmodule

// File: rtl/kwdt_cfg_field.sv
module kwdt_cfg_field #(
   parameter int          W        = 12,
   parameter logic [W-1:0] RST_VAL = '0,
   parameter int          SYNC_DLY = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] din,
   output logic [W-1:0] shadow,
   output logic [W-1:0] active,
   output logic         pending
);
   localparam int SC_W = (SYNC_DLY < 2) ? 1 : $clog2(SYNC_DLY);

   logic [SC_W-1:0] sync_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow   <= RST_VAL;
         active   <= RST_VAL;
         pending  <= 1'b0;
         sync_cnt <= '0;
      end else if (wr) begin
         shadow   <= din;
         pending  <= 1'b1;
         sync_cnt <= SC_W'(SYNC_DLY - 1);
      end else if (pending) begin
         if (sync_cnt == '0) begin
            pending <= 1'b0;
            active  <= shadow;
         end else begin
            sync_cnt <= sync_cnt - 1'b1;
         end
      end
   end
endmodule

// File: rtl/kwdt_tick_gen.sv
module kwdt_tick_gen #(
   parameter int PRE_W     = 3,
   parameter int MIN_SHIFT = 2,
   parameter int MAX_SHIFT = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRE_W-1:0] code,
   input  logic             restart,
   output logic             tick
);
   localparam int NCODE = 1 << PRE_W;
   localparam int CNT_W = MAX_SHIFT;

   logic [CNT_W-1:0] lim [NCODE];
   logic [CNT_W-1:0] pcnt;

   for (genvar g = 0; g < NCODE; g++) begin : g_lim
      localparam int SH = ((g + MIN_SHIFT) > MAX_SHIFT) ? MAX_SHIFT : (g + MIN_SHIFT);
      assign lim[g] = CNT_W'((32'd1 << SH) - 32'd1);
   end

   assign tick = (pcnt >= lim[code]);

   always_ff @(posedge clk) begin
      if (!rst_n)
         pcnt <= '0;
      else if (restart || tick)
         pcnt <= '0;
      else
         pcnt <= pcnt + 1'b1;
   end
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          load,
   input  logic          tick,
   input  logic [CW-1:0] rl_val,
   output logic          rst_req
);
   logic [CW-1:0] cnt;
   logic          expire;

   assign expire = (cnt == '0) || (cnt == CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         rst_req <= 1'b0;
      end else begin
         rst_req <= 1'b0;
         if (load) begin
            cnt <= rl_val;
         end else if (run && tick) begin
            if (expire) begin
               cnt     <= rl_val;
               rst_req <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
   import kwdt_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int RLD_W     = 12,
   parameter int PRE_W     = 3,
   parameter int SYNC_DLY  = 3,
   parameter int MIN_SHIFT = 2,
   parameter int MAX_SHIFT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rst_req
);
   if (DATA_W < 16) begin : g_bad_dw
      $error("DATA_W must hold a 16-bit key");
   end
   if (RLD_W > DATA_W) begin : g_bad_rw
      $error("RLD_W must fit in DATA_W");
   end
   if (SYNC_DLY < 1) begin : g_bad_sd
      $error("SYNC_DLY must be at least 1");
   end
   if (MAX_SHIFT < MIN_SHIFT) begin : g_bad_sh
      $error("MAX_SHIFT must not be below MIN_SHIFT");
   end

   logic             key_wr, start_p, feed_p, acc_open, running;
   logic             pr_wr, rl_wr, pr_pend, rl_pend, tick, load;
   logic [PRE_W-1:0] pr_shadow, pr_active;
   logic [RLD_W-1:0] rl_shadow, rl_active;

   assign key_wr = wr_en && (wr_addr == ADR_KEY);
   assign pr_wr  = wr_en && (wr_addr == ADR_PRE) && acc_open;
   assign rl_wr  = wr_en && (wr_addr == ADR_RLD) && acc_open;
   assign load   = start_p || feed_p;

   kwdt_key_decode u_key (
      .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_val(wr_data[15:0]),
      .start_p(start_p), .feed_p(feed_p), .acc_open(acc_open), .running(running)
   );

   kwdt_cfg_field #(.W(PRE_W), .RST_VAL('0), .SYNC_DLY(SYNC_DLY)) u_pre (
      .clk(clk), .rst_n(rst_n), .wr(pr_wr), .din(wr_data[PRE_W-1:0]),
      .shadow(pr_shadow), .active(pr_active), .pending(pr_pend)
   );

   kwdt_cfg_field #(.W(RLD_W), .RST_VAL('1), .SYNC_DLY(SYNC_DLY)) u_rld (
      .clk(clk), .rst_n(rst_n), .wr(rl_wr), .din(wr_data[RLD_W-1:0]),
      .shadow(rl_shadow), .active(rl_active), .pending(rl_pend)
   );

   kwdt_tick_gen #(.PRE_W(PRE_W), .MIN_SHIFT(MIN_SHIFT), .MAX_SHIFT(MAX_SHIFT)) u_tick (
      .clk(clk), .rst_n(rst_n), .code(pr_active), .restart(load), .tick(tick)
   );

   kwdt_counter #(.CW(RLD_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(running), .load(load), .tick(tick),
      .rl_val(rl_active), .rst_req(rst_req)
   );

   always_comb begin
      case (rd_addr)
         ADR_PRE:  rd_data = DATA_W'(pr_shadow);
         ADR_RLD:  rd_data = DATA_W'(rl_shadow);
         ADR_STAT: rd_data = DATA_W'({rl_pend, pr_pend});
         default:  rd_data = '0;
      endcase
   end
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
   parameter int DATA_W = 16,
   parameter int RLD_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              rst_req,
   input logic              running,
   input logic              acc_open,
   input logic              pr_pend,
   input logic [RLD_W-1:0]  rl_shadow
);
   logic key_wr, known_key;
   assign key_wr    = wr_en && (wr_addr == 2'd0);
   assign known_key = (wr_data[15:0] == 16'hAAAA) || (wr_data[15:0] == 16'hCCCC) ||
                      (wr_data[15:0] == 16'h5555) || (wr_data[15:0] == 16'h0000);

   // R9
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);
   // R2
   req_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> running);
   // R9
   no_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running |=> running);
   // R4
   unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && wr_data[15:0] == 16'h5555) |=> acc_open);
   // R3
   feed_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && wr_data[15:0] == 16'hAAAA) |=> !acc_open);
   // R5
   locked_rld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd2 && !acc_open) |=> $stable(rl_shadow));
   // R8
   pre_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd1 && acc_open) |=> pr_pend);
   // R6
   stray_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && !known_key) |=> $stable(acc_open));
endmodule

bind keyed_wdt keyed_wdt_chk #(.DATA_W(DATA_W), .RLD_W(RLD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .rst_req(rst_req), .running(running), .acc_open(acc_open),
   .pr_pend(pr_pend), .rl_shadow(rl_shadow)
);

// File: tb/keyed_wdt_test.sv
`timescale 1ns/1ps
module keyed_wdt_test;
   localparam int SYNC = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        rst_req;

   int nvec = 0;
   int nbad = 0;
   int cyc  = 0;

   keyed_wdt uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .rst_req(rst_req)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Checks rst_req over n cycles: pulses at distance first, then every per (per 0: none).
   task automatic watch(input string req, input int n, input int t0, input int first, input int per);
      int bad = 0;
      logic a_first = 1'b0, e_first = 1'b0;
      for (int i = 0; i < n; i++) begin
         int d;
         logic e;
         @(negedge clk);
         d = cyc - t0;
         e = (per > 0) && ((d == first) || ((d > first) && (((d - first) % per) == 0)));
         if (rst_req !== e) begin
            if (bad == 0) begin a_first = rst_req; e_first = e; end
            bad++;
         end
      end
      nvec++;
      if (bad != 0) begin
         nbad++;
         $display("FAIL %s: %0d cycle mismatches, first actual %0b expected %0b", req, bad, a_first, e_first);
      end
   endtask

   task automatic t_reset();
      logic [15:0] v;
      rd(2'd2, v); chk("R1 reload", v, 16'hFFF);
      rd(2'd1, v); chk("R1 prescaler", v, 0);
      rd(2'd3, v); chk("R1 status", v, 0);
      rd(2'd0, v); chk("R1 key read", v, 0);
      watch("R1 idle", 50, cyc, 0, 0);
   endtask

   task automatic t_locked();
      logic [15:0] v;
      wr(2'd2, 16'h0123);
      rd(2'd2, v); chk("R5 reload locked", v, 16'hFFF);
      rd(2'd3, v); chk("R5 status locked", v, 0);
      wr(2'd1, 16'h0005);
      rd(2'd1, v); chk("R5 prescaler locked", v, 0);
   endtask

   task automatic t_stray();
      logic [15:0] v;
      wr(2'd0, 16'h1234);
      wr(2'd0, 16'hCCCD);
      watch("R6 stray key no start", 100, cyc, 0, 0);
      wr(2'd0, 16'h5555);
      wr(2'd0, 16'h1234);
      wr(2'd2, 16'h00AB);
      rd(2'd2, v); chk("R6 stray key keeps access", v, 16'h0AB);
      idle(SYNC + 1);
   endtask

   task automatic t_access();
      logic [15:0] v;
      wr(2'd2, 16'hF005);
      rd(2'd2, v); chk("R10 reload truncation", v, 16'h005);
      rd(2'd3, v); chk("R8 reload pending set", v, 2);
      idle(SYNC - 1);
      rd(2'd3, v); chk("R8 reload pending held", v, 2);
      idle(1);
      rd(2'd3, v); chk("R8 reload pending cleared", v, 0);
      wr(2'd1, 16'h0009);
      rd(2'd1, v); chk("R10 prescaler truncation", v, 1);
      rd(2'd3, v); chk("R8 prescaler pending set", v, 1);
      idle(SYNC);
      rd(2'd3, v); chk("R8 prescaler pending cleared", v, 0);
      wr(2'd0, 16'h0000);
      wr(2'd2, 16'h0007);
      rd(2'd2, v); chk("R4 lock key closes", v, 16'h005);
      wr(2'd0, 16'h5555);
      wr(2'd2, 16'h0006);
      rd(2'd2, v); chk("R4 unlock key opens", v, 16'h006);
      idle(SYNC + 1);
      wr(2'd0, 16'hAAAA);
      wr(2'd2, 16'h0009);
      rd(2'd2, v); chk("R3 feed closes access", v, 16'h006);
      rd(2'd3, v); chk("R5 status after locked write", v, 0);
      watch("R2 feed while idle no start", 60, cyc, 0, 0);
   endtask

   task automatic t_default_period();
      logic [15:0] v;
      int t0;
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd(2'd2, v); chk("R1 reload after second reset", v, 16'hFFF);
      rd(2'd1, v); chk("R1 prescaler after second reset", v, 0);
      wr(2'd0, 16'hCCCC);
      t0 = cyc;
      watch("R2 default period 16380", 16400, t0, 16380, 16380);
   endtask

   task automatic t_feed();
      int t0;
      wr(2'd0, 16'h5555);
      wr(2'd1, 16'h0001);
      wr(2'd2, 16'h0006);
      idle(SYNC + 1);
      wr(2'd0, 16'hAAAA);
      t0 = cyc;
      watch("R9 repeating period 48", 120, t0, 48, 48);
      for (int k = 0; k < 3; k++) begin
         wr(2'd0, 16'hAAAA);
         t0 = cyc;
         watch("R3 feed restarts count", 40, t0, 48, 48);
      end
      wr(2'd0, 16'h0000);
      wr(2'd0, 16'hFFFF);
      watch("R9 cannot stop", 60, t0, 48, 48);
   endtask

   task automatic t_presc();
      int codes[3] = '{7, 6, 3};
      int rls[3]   = '{2, 1, 3};
      int pers[3]  = '{512, 256, 96};
      for (int k = 0; k < 3; k++) begin
         int t0;
         wr(2'd0, 16'h5555);
         wr(2'd1, 16'(codes[k]));
         wr(2'd2, 16'(rls[k]));
         idle(SYNC + 1);
         wr(2'd0, 16'hAAAA);
         t0 = cyc;
         watch($sformatf("R7 code %0d", codes[k]), 2 * pers[k] + 8, t0, pers[k], pers[k]);
      end
   endtask

   task automatic t_sync_effect();
      logic [15:0] v;
      int t0;
      wr(2'd0, 16'h5555);
      wr(2'd1, 16'h0000);
      wr(2'd2, 16'h0000);
      idle(SYNC + 1);
      wr(2'd0, 16'hAAAA);
      t0 = cyc;
      watch("R2 reload zero", 20, t0, 4, 4);
      wr(2'd0, 16'h5555);
      wr(2'd2, 16'h0003);
      rd(2'd3, v); chk("R8 pending before feed", v, 2);
      wr(2'd0, 16'hAAAA);
      t0 = cyc;
      watch("R8 old value until sync", 40, t0, 4, 12);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      t_reset();
      t_locked();
      t_stray();
      t_access();
      t_default_period();
      t_feed();
      t_presc();
      t_sync_effect();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      #(8 * 190000);
      nvec++;
      nbad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule